// File: doc/BRIEF.md
# Bridge Function-0 Configuration Space

This block holds the 256-byte configuration space of function 0 of a bus-to-ISA bridge. A byte-wide register port carries a function number, an 8-bit offset, a write strobe with write data and a read strobe. Only function 0 has storage. Any other function reads as all ones and drops its writes. On reset every byte is loaded from a computed table. The identification bytes come from module parameters, and every offset not listed below resets to zero.

A small set of header offsets is protected against writes. Bit 6 of two control bytes is also watched, and each watched bit drives a level enable. The first enable turns on aliasing of the DMA register ports. The second turns on an alternate reset/A20 control port. An enable moves only when a write actually flips its bit, measured against the byte held before that write. The DMA controller and the port logic that use these enables sit outside the block.

Top module: `bridge_cfg_space`

## Requirements
- R1: After reset, offsets 0x04=0x07, 0x07=0x02, 0x40=0x20, 0x42=0x24, 0x45=0x10, 0x46=0x0F, 0x48=0x01, 0x4A=0x10, 0x4B=0x0F, 0x4C=0x56, 0x4D=0x40, 0x4E=0x07, 0x4F=0x4F, 0x60..0x63=0x80, 0x80=0x78, 0xA0=0x08 and 0xA8=0x0F. Every other offset except those in R2 reads 0x00.
- R2: Offset 0x00 holds VEND_ID[7:0] and 0x01 holds VEND_ID[15:8]. Offset 0x02 holds DEV_ID[7:0] and 0x03 holds DEV_ID[15:8]. Offset 0x08 holds REV_ID.
- R3: A read strobe at a clock edge loads rd_data with the addressed byte at that edge. Without a read strobe, rd_data holds its value.
- R4: A write strobe with fn_sel=0 to any offset outside R5 stores wr_data, and a later read of that offset returns it.
- R5: Writes to offsets 0x00..0x03, 0x08..0x0B and 0x0E leave those bytes unchanged.
- R6: With fn_sel other than 0, a read returns 0xFF and a write changes no byte and no enable.
- R7: dma_alias_en is 1 after reset. A function-0 write to offset 0x40 that changes bit 6 sets dma_alias_en to the inverse of the new bit 6 at that edge.
- R8: alt_port_en is 1 after reset. A function-0 write to offset 0x4F that changes bit 6 sets alt_port_en to the new bit 6 at that edge.
- R9: Writes that leave bit 6 of 0x40 or 0x4F unchanged, and writes to any other offset, leave both enables unchanged.
- R10: A read and a write to the same offset in the same cycle return the byte held before the write. The written byte is returned by the next read. An enable toggled by that write still updates at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fn_sel | input | FN_W | Function number of the access |
| reg_off | input | OFF_W | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read data |
| dma_alias_en | output | 1 | DMA register alias enable |
| alt_port_en | output | 1 | Alternate reset/A20 port enable |

## Verification
A read and a write can fall in the same cycle, and so can a byte update and the enable change detection that reads the old value of that same byte. The bench raises both strobes together at one offset, including control offset 0x40 with bit 6 flipped. The read must return the pre-write byte, the enable must move at that same edge, and a follow-up read must return the new byte.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

  localparam logic [7:0] CTL_DMA_OFF = 8'h40;
  localparam logic [7:0] CTL_ALT_OFF = 8'h4F;
  localparam int         CTL_BIT     = 6;

  // Header bytes that software may not alter
  function automatic logic is_locked(input logic [7:0] off);
    return (off <= 8'h03) || (off >= 8'h08 && off <= 8'h0B) || (off == 8'h0E);
  endfunction

  // Power-on content of one byte
  function automatic logic [7:0] reset_val(input logic [7:0] off,
                                            input logic [15:0] vend,
                                            input logic [15:0] dev,
                                            input logic [7:0]  rev);
    logic [7:0] v;
    case (off)
      8'h00: v = vend[7:0];
      8'h01: v = vend[15:8];
      8'h02: v = dev[7:0];
      8'h03: v = dev[15:8];
      8'h08: v = rev;
      8'h04, 8'h4E: v = 8'h07;
      8'h07: v = 8'h02;
      8'h40: v = 8'h20;
      8'h42: v = 8'h24;
      8'h45, 8'h4A: v = 8'h10;
      8'h46, 8'h4B, 8'hA8: v = 8'h0F;
      8'h48: v = 8'h01;
      8'h4C: v = 8'h56;
      8'h4D: v = 8'h40;
      8'h4F: v = 8'h4F;
      8'h60, 8'h61, 8'h62, 8'h63: v = 8'h80;
      8'h80: v = 8'h78;
      8'hA0: v = 8'h08;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/cfg_byte_array.sv
module cfg_byte_array #(
  parameter int          OFF_W   = 8,
  parameter int          DATA_W  = 8,
  parameter logic [15:0] VEND_ID = 16'h1D5C,
  parameter logic [15:0] DEV_ID  = 16'h0484,
  parameter logic [7:0]  REV_ID  = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_commit,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] cur_byte
);
  localparam int DEPTH = 1 << OFF_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam logic [DATA_W-1:0] RST_V =
      DATA_W'(cfgsp_pkg::reset_val(8'(g), VEND_ID, DEV_ID, REV_ID));
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] d;
    logic              hit;

    always_comb begin
      hit = wr_commit && (off == OFF_W'(g));
      d   = hit ? wr_data : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_V;
      else        q <= d;
    end

    assign mem_q[g] = q;
  end

  // Pre-write content of the addressed byte: feeds reads and change detection
  assign cur_byte = mem_q[off];
endmodule

// File: rtl/cfg_bit_watch.sv
module cfg_bit_watch #(
  parameter logic INVERT  = 1'b0,
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic new_bit,
  input  logic old_bit,
  output logic en
);
  logic en_q;
  logic en_d;
  logic flip;

  always_comb begin
    flip = sel && (new_bit ^ old_bit);
    en_d = flip ? (new_bit ^ INVERT) : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= RST_LVL;
    else        en_q <= en_d;
  end

  assign en = en_q;
endmodule

// File: rtl/bridge_cfg_space.sv
module bridge_cfg_space #(
  parameter int          FN_W    = 3,
  parameter int          OFF_W   = 8,
  parameter int          DATA_W  = 8,
  parameter logic [15:0] VEND_ID = 16'h1D5C,
  parameter logic [15:0] DEV_ID  = 16'h0484,
  parameter logic [7:0]  REV_ID  = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FN_W-1:0]   fn_sel,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              dma_alias_en,
  output logic              alt_port_en
);
  localparam int CB = cfgsp_pkg::CTL_BIT;

  logic              rst_sync_n;
  logic              fn0;
  logic              wr_commit;
  logic [DATA_W-1:0] cur_byte;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] rd_d;
  logic              sel_dma;
  logic              sel_alt;

  cfg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    fn0       = (fn_sel == '0);
    wr_commit = wr_en && fn0 && !cfgsp_pkg::is_locked(8'(reg_off));
    sel_dma   = wr_commit && (reg_off == OFF_W'(cfgsp_pkg::CTL_DMA_OFF));
    sel_alt   = wr_commit && (reg_off == OFF_W'(cfgsp_pkg::CTL_ALT_OFF));
  end

  cfg_byte_array #(
    .OFF_W   (OFF_W),
    .DATA_W  (DATA_W),
    .VEND_ID (VEND_ID),
    .DEV_ID  (DEV_ID),
    .REV_ID  (REV_ID)
  ) u_arr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_commit (wr_commit),
    .off       (reg_off),
    .wr_data   (wr_data),
    .cur_byte  (cur_byte)
  );

  // Aliasing is on while the control bit is clear
  cfg_bit_watch #(.INVERT(1'b1), .RST_LVL(1'b1)) u_dma_watch (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sel     (sel_dma),
    .new_bit (wr_data[CB]),
    .old_bit (cur_byte[CB]),
    .en      (dma_alias_en)
  );

  cfg_bit_watch #(.INVERT(1'b0), .RST_LVL(1'b1)) u_alt_watch (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sel     (sel_alt),
    .new_bit (wr_data[CB]),
    .old_bit (cur_byte[CB]),
    .en      (alt_port_en)
  );

  // Read port: capture on strobe, otherwise hold
  always_comb begin
    rd_d = rd_q;
    if (rd_en) rd_d = fn0 ? cur_byte : '1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_q <= '0;
    else             rd_q <= rd_d;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/bridge_cfg_space_chk.sv
module bridge_cfg_space_chk #(
  parameter int          FN_W    = 3,
  parameter int          OFF_W   = 8,
  parameter int          DATA_W  = 8,
  parameter logic [15:0] VEND_ID = 16'h1D5C
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FN_W-1:0]   fn_sel,
  input logic [OFF_W-1:0]  reg_off,
  input logic              wr_en,
  input logic              wr_bit6,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              dma_alias_en,
  input logic              alt_port_en
);
  logic to_dma;
  logic to_alt;
  assign to_dma = wr_en && (fn_sel == '0) && (reg_off == OFF_W'(8'h40));
  assign to_alt = wr_en && (fn_sel == '0) && (reg_off == OFF_W'(8'h4F));

  a_r3_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  a_r6_foreign_fn_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fn_sel != '0) |=> (rd_data == '1));

  a_r2_vendor_low_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fn_sel == '0 && reg_off == '0) |=> (rd_data == DATA_W'(VEND_ID[7:0])));

  a_r7_dma_tracks_bit: assert property (@(posedge clk) disable iff (!rst_n)
    to_dma |=> (dma_alias_en == !$past(wr_bit6)));

  a_r8_alt_tracks_bit: assert property (@(posedge clk) disable iff (!rst_n)
    to_alt |=> (alt_port_en == $past(wr_bit6)));

  a_r9_dma_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !to_dma |=> $stable(dma_alias_en));

  a_r9_alt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !to_alt |=> $stable(alt_port_en));
endmodule

bind bridge_cfg_space bridge_cfg_space_chk #(
  .FN_W    (FN_W),
  .OFF_W   (OFF_W),
  .DATA_W  (DATA_W),
  .VEND_ID (VEND_ID)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .fn_sel       (fn_sel),
  .reg_off      (reg_off),
  .wr_en        (wr_en),
  .wr_bit6      (wr_data[6]),
  .rd_en        (rd_en),
  .rd_data      (rd_data),
  .dma_alias_en (dma_alias_en),
  .alt_port_en  (alt_port_en)
);

// File: tb/test_bridge_cfg_space.sv
`timescale 1ns/1ps
module test_bridge_cfg_space;
  localparam logic [15:0] TB_VEND = 16'hBEEF;
  localparam logic [15:0] TB_DEV  = 16'h0C42;
  localparam logic [7:0]  TB_REV  = 8'h05;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] fn_sel = '0;
  logic [7:0] reg_off = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       dma_alias_en;
  logic       alt_port_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bridge_cfg_space #(
    .VEND_ID (TB_VEND), .DEV_ID (TB_DEV), .REV_ID (TB_REV)
  ) i_bridge_cfg_space (
    .clk (clk), .rst_n (rst_n), .fn_sel (fn_sel), .reg_off (reg_off),
    .wr_en (wr_en), .wr_data (wr_data), .rd_en (rd_en), .rd_data (rd_data),
    .dma_alias_en (dma_alias_en), .alt_port_en (alt_port_en)
  );

  function automatic logic [7:0] exp_reset(input int o);
    if (o == 8'h00) return TB_VEND[7:0];
    if (o == 8'h01) return TB_VEND[15:8];
    if (o == 8'h02) return TB_DEV[7:0];
    if (o == 8'h03) return TB_DEV[15:8];
    if (o == 8'h08) return TB_REV;
    if (o == 8'h04 || o == 8'h4E) return 8'h07;
    if (o == 8'h07) return 8'h02;
    if (o == 8'h40) return 8'h20;
    if (o == 8'h42) return 8'h24;
    if (o == 8'h45 || o == 8'h4A) return 8'h10;
    if (o == 8'h46 || o == 8'h4B || o == 8'hA8) return 8'h0F;
    if (o == 8'h48) return 8'h01;
    if (o == 8'h4C) return 8'h56;
    if (o == 8'h4D) return 8'h40;
    if (o == 8'h4F) return 8'h4F;
    if (o >= 8'h60 && o <= 8'h63) return 8'h80;
    if (o == 8'h80) return 8'h78;
    if (o == 8'hA0) return 8'h08;
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] f, input logic [7:0] o, input logic [7:0] d);
    @(negedge clk);
    fn_sel = f; reg_off = o; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] f, input logic [7:0] o, output logic [7:0] d);
    @(negedge clk);
    fn_sel = f; reg_off = o; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    int bad_before;
    chk("R3 reset rd_data", rd_data, 8'h00);
    chk("R7 reset dma_alias_en", {7'd0, dma_alias_en}, 8'h01);
    chk("R8 reset alt_port_en", {7'd0, alt_port_en}, 8'h01);
    bad_before = n_bad;
    for (int o = 0; o < 256; o++) begin
      do_read(3'd0, 8'(o), v);
      if (o <= 3 || o == 8) chk("R2 id byte", v, exp_reset(o));
      else                  chk("R1 reset byte", v, exp_reset(o));
    end
    if (n_bad != bad_before) $display("  (R1/R2 reset sweep had mismatches)");
  endtask

  task automatic t_rw;
    logic [7:0] v;
    do_write(3'd0, 8'h10, 8'h55);
    do_write(3'd0, 8'hFF, 8'hAA);
    do_write(3'd0, 8'h04, 8'h3C);
    do_read(3'd0, 8'h10, v); chk("R4 offset 10", v, 8'h55);
    do_read(3'd0, 8'hFF, v); chk("R4 offset FF", v, 8'hAA);
    do_read(3'd0, 8'h04, v); chk("R4 offset 04", v, 8'h3C);
    do_read(3'd0, 8'h10, v);
    @(negedge clk); reg_off = 8'hFF;
    @(negedge clk); @(negedge clk);
    chk("R3 hold without strobe", rd_data, 8'h55);
  endtask

  task automatic t_locked;
    logic [7:0] v;
    logic [7:0] lst [9] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0E};
    for (int i = 0; i < 9; i++) do_write(3'd0, lst[i], 8'h5A);
    for (int i = 0; i < 9; i++) begin
      do_read(3'd0, lst[i], v);
      chk("R5 locked byte", v, exp_reset(int'(lst[i])));
    end
    do_write(3'd0, 8'h0F, 8'h5A);
    do_read(3'd0, 8'h0F, v); chk("R4 neighbour 0F writable", v, 8'h5A);
  endtask

  task automatic t_foreign;
    logic [7:0] v;
    do_read(3'd1, 8'h04, v); chk("R6 fn1 reads FF", v, 8'hFF);
    do_read(3'd7, 8'h00, v); chk("R6 fn7 reads FF", v, 8'hFF);
    do_write(3'd2, 8'h10, 8'h33);
    do_read(3'd0, 8'h10, v); chk("R6 fn2 write dropped", v, 8'h55);
    do_write(3'd1, 8'h40, 8'h60);
    chk("R6 fn1 write no dma change", {7'd0, dma_alias_en}, 8'h01);
    do_read(3'd0, 8'h40, v); chk("R6 fn1 write no store", v, 8'h20);
  endtask

  task automatic t_dma;
    do_write(3'd0, 8'h40, 8'h21);
    chk("R9 bit6 unchanged dma", {7'd0, dma_alias_en}, 8'h01);
    do_write(3'd0, 8'h40, 8'h60);
    chk("R7 bit6 set -> alias off", {7'd0, dma_alias_en}, 8'h00);
    do_write(3'd0, 8'h40, 8'h40);
    chk("R9 bit6 stays set", {7'd0, dma_alias_en}, 8'h00);
    do_write(3'd0, 8'h40, 8'h20);
    chk("R7 bit6 clear -> alias on", {7'd0, dma_alias_en}, 8'h01);
  endtask

  task automatic t_alt;
    do_write(3'd0, 8'h4F, 8'h0F);
    chk("R8 bit6 clear -> port off", {7'd0, alt_port_en}, 8'h00);
    do_write(3'd0, 8'h41, 8'h40);
    chk("R9 other offset dma", {7'd0, dma_alias_en}, 8'h01);
    chk("R9 other offset alt", {7'd0, alt_port_en}, 8'h00);
    do_write(3'd0, 8'h4F, 8'h4F);
    chk("R8 bit6 set -> port on", {7'd0, alt_port_en}, 8'h01);
    chk("R9 alt write leaves dma", {7'd0, dma_alias_en}, 8'h01);
  endtask

  task automatic t_same_cycle;
    logic [7:0] v;
    @(negedge clk);
    fn_sel = 3'd0; reg_off = 8'h20; wr_data = 8'h77; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R10 read returns old byte", rd_data, 8'h00);
    do_read(3'd0, 8'h20, v); chk("R10 next read new byte", v, 8'h77);
    @(negedge clk);
    reg_off = 8'h40; wr_data = 8'h60; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R10 ctl read old byte", rd_data, 8'h20);
    chk("R10 enable moves same edge", {7'd0, dma_alias_en}, 8'h00);
    do_read(3'd0, 8'h40, v); chk("R10 ctl new byte", v, 8'h60);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rw();
    t_locked();
    t_foreign();
    t_dma();
    t_alt();
    t_same_cycle();
    finish_run();
  end
endmodule